// File: doc/BRIEF.md
# Frame-update interrupt controller

This block holds the frame-buffer base address of a display controller and the interrupt registers around it. Software may write a new base address at any moment. The value waits in a shadow register until the next start-of-frame pulse from the timing generator. On that pulse it moves into the active base register that feeds the fetch engine, and a "base taken" status bit is raised at the same edge. The interrupt therefore reports when the new address actually takes effect, not when it was written.

The status bank also holds a few placeholder event bits for other interrupt sources. Each bit has an enable. Software reads both the raw status and the status after the enable mask, and clears bits by writing ones to a clear register. A single interrupt line is the OR of the masked status, delayed by one register stage.

Register access uses a plain synchronous bus. A write completes on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational and is valid while `bus_sel` is high and `bus_wr` is low. Word addresses: 0 shadow base (read/write), 1 active base (read only), 2 enable (read/write), 3 raw status (read only), 4 masked status (read only), 5 clear (write only).

Top module: `fbirq_ctrl`

## Requirements
- R1: After reset, the active base, the shadow base, enable, raw status, masked status and `irq_o` are all zero.
- R2: A write to address 0 stores the data in the shadow register with bits [1:0] forced to zero. Reading address 0 returns the stored value.
- R3: `base_o` and address 1 keep their value while no load occurs, however many shadow writes take place.
- R4: A start-of-frame pulse that arrives while a shadow write is pending copies the shadow into the active base and sets raw status bit 2 at the same edge. Both are visible in the following cycle. A pulse with nothing pending changes neither.
- R5: If a shadow write and a start-of-frame pulse share a cycle while an older write is pending, the older value is loaded. The new value stays pending and is loaded by the next pulse.
- R6: Address 4 reads as raw status AND enable, in bits [4:0].
- R7: Writing to address 5 clears the raw bits where the data has ones and leaves the bits where it has zeros.
- R8: When a bit is set and cleared in the same cycle, it ends up set.
- R9: `irq_o` equals the OR of the masked status of the previous cycle. With enable zero it stays low whatever the status.
- R10: A pulse on `src_evt[i]` sets raw bit i, for every i except 2. `src_evt[2]` is ignored, because bit 2 is owned by the base-load event.
- R11: Writes to addresses 1, 3 and 4 have no effect, and reading address 5 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, zero when not reading |
| frame_start | input | 1 | One-cycle start-of-frame pulse |
| src_evt | input | NUM_SRC | Placeholder event pulses |
| base_o | output | DATA_W | Active frame-buffer base |
| irq_o | output | 1 | Interrupt request |

## Verification
The base-load path is exercised with three patterns:
- A write followed by a later frame pulse, which separates the shadow from the active register.
- A frame pulse with nothing pending, which shows whether the pending flag is really consulted.
- A write that lands in the same cycle as a frame pulse, which shows whether the old or the new value is loaded.

The status bank is driven with clears of ones and of zeros, with a set and a clear in the same cycle, and with enable set fully, partly and not at all. These show the masked view, the priority of set over clear and the one-cycle delay of the interrupt line. A behavioural model is compared against `base_o` and `irq_o` on every clock. It is also compared against each read.

// File: rtl/fbirq_pkg.sv
package fbirq_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_SHADOW = 3'd0,
      REG_ACTIVE = 3'd1,
      REG_ENABLE = 3'd2,
      REG_RAW    = 3'd3,
      REG_MASKED = 3'd4,
      REG_CLEAR  = 3'd5
   } reg_addr_e;
endpackage

// File: rtl/fbirq_base_shadow.sv
module fbirq_base_shadow #(
   parameter int DATA_W     = 32,
   parameter int ALIGN_BITS = 2,
   parameter logic [DATA_W-1:0] RESET_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              frame_start,
   output logic [DATA_W-1:0] shadow_q,
   output logic [DATA_W-1:0] active_q,
   output logic              load_pulse
);
   localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((64'd1 << ALIGN_BITS) - 64'd1);

   logic              pending_q;
   logic [DATA_W-1:0] aligned;

   assign aligned    = wr_data & ~LOW_MASK;
   assign load_pulse = frame_start & pending_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q  <= RESET_BASE;
         active_q  <= RESET_BASE;
         pending_q <= 1'b0;
      end else begin
         if (wr_en)      shadow_q <= aligned;
         if (load_pulse) active_q <= shadow_q;
         pending_q <= wr_en | (pending_q & ~frame_start);
      end
   end

   // R3: no load, active base holds
   a_r3_active_holds : assert property (@(posedge clk) disable iff (!rst_n)
      !load_pulse |=> $stable(active_q));
   // R4: load takes the pre-edge shadow value
   a_r4_load_copies : assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |=> active_q == $past(shadow_q));
   // R5: a write in the load cycle stays pending for the next pulse
   a_r5_write_stays_pending : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && frame_start) |=> pending_q);
endmodule

// File: rtl/fbirq_status.sv
module fbirq_status #(
   parameter int NUM_SRC        = 5,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_vec,
   input  logic [NUM_SRC-1:0] clr_vec,
   input  logic [NUM_SRC-1:0] en_vec,
   output logic [NUM_SRC-1:0] raw_q,
   output logic [NUM_SRC-1:0] masked,
   output logic               irq
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          raw_q[i] <= 1'b0;
         else if (set_vec[i]) raw_q[i] <= 1'b1;
         else if (clr_vec[i]) raw_q[i] <= 1'b0;
      end
   end

   assign masked = raw_q & en_vec;

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |masked;
      end
      assign irq = irq_q;
      // R9: line follows the previous cycle's masked status
      a_r9_irq_delayed : assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> irq == $past(|masked));
   end else begin : g_irq_comb
      assign irq = |masked;
   end

   // R7: cleared bits without a set go low
   a_r7_clear_ones : assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_vec & ~set_vec) != '0) |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0));
   // R8: set wins
   a_r8_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/fbirq_ctrl.sv
module fbirq_ctrl #(
   parameter int DATA_W         = 32,
   parameter int NUM_SRC        = 5,
   parameter int NBU_BIT        = 2,
   parameter int ALIGN_BITS     = 2,
   parameter bit IRQ_REGISTERED = 1'b1,
   parameter logic [DATA_W-1:0] RESET_BASE = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_sel,
   input  logic                        bus_wr,
   input  logic [fbirq_pkg::ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   input  logic                        frame_start,
   input  logic [NUM_SRC-1:0]          src_evt,
   output logic [DATA_W-1:0]           base_o,
   output logic                        irq_o
);
   import fbirq_pkg::*;

   localparam logic [NUM_SRC-1:0] NBU_ONEHOT = NUM_SRC'(1) << NBU_BIT;

   if (NBU_BIT >= NUM_SRC)    begin : g_chk_bit   $error("NBU_BIT outside status");  end
   if (NUM_SRC > DATA_W)      begin : g_chk_src   $error("NUM_SRC wider than bus");  end
   if (ALIGN_BITS >= DATA_W)  begin : g_chk_align $error("ALIGN_BITS too large");    end

   logic               wr_cyc, rd_cyc;
   logic [DATA_W-1:0]  shadow_q, active_q;
   logic               load_pulse;
   logic [NUM_SRC-1:0] en_q, set_vec, clr_vec, raw_q, masked;

   assign wr_cyc = bus_sel & bus_wr;
   assign rd_cyc = bus_sel & ~bus_wr;

   fbirq_base_shadow #(
      .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS), .RESET_BASE(RESET_BASE)
   ) u_base (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_cyc && bus_addr == REG_SHADOW),
      .wr_data(bus_wdata),
      .frame_start(frame_start),
      .shadow_q(shadow_q), .active_q(active_q), .load_pulse(load_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               en_q <= '0;
      else if (wr_cyc && bus_addr == REG_ENABLE) en_q <= bus_wdata[NUM_SRC-1:0];
   end

   always_comb begin
      set_vec = (src_evt & ~NBU_ONEHOT) | (load_pulse ? NBU_ONEHOT : '0);
      clr_vec = (wr_cyc && bus_addr == REG_CLEAR) ? bus_wdata[NUM_SRC-1:0] : '0;
   end

   fbirq_status #(
      .NUM_SRC(NUM_SRC), .IRQ_REGISTERED(IRQ_REGISTERED)
   ) u_stat (
      .clk(clk), .rst_n(rst_n),
      .set_vec(set_vec), .clr_vec(clr_vec), .en_vec(en_q),
      .raw_q(raw_q), .masked(masked), .irq(irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      if (rd_cyc) begin
         case (bus_addr)
            REG_SHADOW: bus_rdata = shadow_q;
            REG_ACTIVE: bus_rdata = active_q;
            REG_ENABLE: bus_rdata = DATA_W'(en_q);
            REG_RAW:    bus_rdata = DATA_W'(raw_q);
            REG_MASKED: bus_rdata = DATA_W'(masked);
            default:    bus_rdata = '0;
         endcase
      end
   end

   assign base_o = active_q;

   // R9: enable zero and not being rewritten keeps the line low
   a_r9_disabled_low : assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0 && !(wr_cyc && bus_addr == REG_ENABLE)) |=> !irq_o);
   // R10: an external pulse on the base-load bit alone never sets it
   a_r10_nbu_ext_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (!load_pulse && !raw_q[NBU_BIT]) |=> !raw_q[NBU_BIT]);
endmodule

// File: tb/fbirq_ctrl_bench.sv
module fbirq_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        frame_start = 1'b0;
   logic [4:0]  src_evt = '0;
   logic [31:0] base_o;
   logic        irq_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fbirq_ctrl u_fbirq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .frame_start(frame_start), .src_evt(src_evt), .base_o(base_o), .irq_o(irq_o)
   );

   // behavioural reference
   logic [31:0] m_shadow = '0, m_active = '0;
   logic [4:0]  m_en = '0, m_raw = '0;
   bit          m_pend = 1'b0, m_irq = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_shadow = '0; m_active = '0; m_en = '0; m_raw = '0; m_pend = 0; m_irq = 0;
      end else begin
         bit wr, ld;
         logic [4:0] setv, clrv;
         wr   = bus_sel && bus_wr;
         ld   = frame_start && m_pend;
         setv = {src_evt[4:3], ld, src_evt[1:0]};
         clrv = (wr && bus_addr == 3'd5) ? bus_wdata[4:0] : 5'd0;
         m_irq = |(m_raw & m_en);
         m_raw = (m_raw & ~clrv) | setv;
         if (ld) m_active = m_shadow;
         m_pend = (wr && bus_addr == 3'd0) || (m_pend && !frame_start);
         if (wr && bus_addr == 3'd0) m_shadow = {bus_wdata[31:2], 2'b00};
         if (wr && bus_addr == 3'd2) m_en = bus_wdata[4:0];
      end
   end

   function automatic logic [31:0] model_read(input logic [2:0] a);
      case (a)
         3'd0: return m_shadow;
         3'd1: return m_active;
         3'd2: return {27'd0, m_en};
         3'd3: return {27'd0, m_raw};
         3'd4: return {27'd0, m_raw & m_en};
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // every-cycle comparison of the registered outputs (R3, R9)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R3 base_o vs model", base_o, m_active);
         check("R9 irq_o vs model", {31'd0, irq_o}, {31'd0, m_irq});
      end
   end

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit fs = 0, input logic [4:0] ev = '0);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; frame_start = fs; src_evt = ev;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; frame_start = 0; src_evt = '0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
      check({tag, " (model)"}, bus_rdata, model_read(a));
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic pulse(input bit fs, input logic [4:0] ev);
      frame_start = fs; src_evt = ev;
      @(negedge clk);
      frame_start = 0; src_evt = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 base_o after reset", base_o, 0);
      check("R1 irq_o after reset", {31'd0, irq_o}, 0);
      rd(3'd0, 32'h0, "R1 shadow");
      rd(3'd2, 32'h0, "R1 enable");
      rd(3'd3, 32'h0, "R1 raw");
      rd(3'd4, 32'h0, "R1 masked");

      // R2 alignment, R3 hold
      wr(3'd0, 32'h1234_5677);
      rd(3'd0, 32'h1234_5674, "R2 shadow aligned");
      rd(3'd1, 32'h0, "R3 active before frame");
      wr(3'd0, 32'h1234_5679);
      idle(3);
      check("R3 base_o held", base_o, 0);

      // R4 load on frame start
      pulse(1, '0);
      check("R4 base_o loaded", base_o, 32'h1234_5678);
      rd(3'd3, 32'h4, "R4 status bit 2 set");
      rd(3'd4, 32'h0, "R6 masked with enable zero");
      check("R9 irq low, enable zero", {31'd0, irq_o}, 0);

      // R7 clear with zeros then ones
      wr(3'd5, 32'h0);
      rd(3'd3, 32'h4, "R7 zeros keep bit");
      wr(3'd5, 32'h4);
      rd(3'd3, 32'h0, "R7 ones clear bit");

      // R4 frame start with nothing pending
      pulse(1, '0);
      rd(3'd3, 32'h0, "R4 no pending no status");
      check("R4 base unchanged", base_o, 32'h1234_5678);

      // R6/R9 with enable all
      wr(3'd2, 32'h1F);
      wr(3'd0, 32'h0000_00A0);
      pulse(1, '0);
      check("R9 irq one cycle late", {31'd0, irq_o}, 0);
      @(negedge clk);
      check("R9 irq asserted", {31'd0, irq_o}, 1);
      rd(3'd4, 32'h4, "R6 masked all enabled");
      wr(3'd5, 32'h4);
      check("R9 irq still high after clear edge", {31'd0, irq_o}, 1);
      @(negedge clk);
      check("R9 irq drops", {31'd0, irq_o}, 0);

      // R8 set and clear in the same cycle
      wr(3'd0, 32'h0000_0100);
      wr(3'd5, 32'h4, 1);
      rd(3'd3, 32'h4, "R8 set wins over clear");
      wr(3'd5, 32'h1F);

      // R5 write in same cycle as load
      wr(3'd0, 32'h0000_0200);
      wr(3'd0, 32'h0000_0303, 1);
      check("R5 older value loaded", base_o, 32'h0000_0200);
      rd(3'd0, 32'h0000_0300, "R5 new value in shadow");
      pulse(1, '0);
      check("R5 new value loaded next frame", base_o, 32'h0000_0300);
      wr(3'd5, 32'h1F);

      // R10 placeholder events
      pulse(0, 5'b00100);
      rd(3'd3, 32'h0, "R10 ext bit 2 ignored");
      pulse(0, 5'b10001);
      rd(3'd3, 32'h11, "R10 ext bits 0 and 4 set");
      wr(3'd2, 32'h01);
      rd(3'd4, 32'h01, "R6 partial enable");
      wr(3'd2, 32'h0);
      idle(2);
      check("R9 enable zero keeps irq low", {31'd0, irq_o}, 0);
      pulse(0, 5'b11011);
      idle(2);
      check("R9 enable zero with events", {31'd0, irq_o}, 0);

      // R11 read-only and write-only registers
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd3, 32'h0);
      wr(3'd4, 32'h0);
      rd(3'd1, 32'h0000_0300, "R11 active not writable");
      rd(3'd3, 32'h1B, "R11 raw not writable");
      rd(3'd5, 32'h0, "R11 clear reads zero");
      check("R11 base_o untouched", base_o, 32'h0000_0300);

      idle(2);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule